// File: doc/BRIEF.md
# Dual-Region Character Buffer with Per-Region Backspace

This block sits between a serial byte receiver and a screen renderer that splits the display into two halves. Bytes arrive one at a time, each marked by a single-cycle strobe. The block sorts them by character class. A byte with its top bit clear is a single-byte letter or digit and is stored at once in the narrow list, which the renderer draws on the right half. A byte with its top bit set opens a two-byte CJK character. It is held until the next byte arrives, then both are joined into one 16-bit code and stored in the wide list, which is drawn on the left half.

Each list has its own one-cycle delete input, already debounced. A pulse removes the newest character of that list only. The renderer reads the lists through two combinational read ports: it gives a slot index and gets back the stored code and a valid flag. Both list lengths are also exported. The block runs entirely on the control clock. Any crossing into the pixel clock belongs to the renderer.

Top module: `dual_text_buffer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both lengths become 0, every read port reports not valid, and any held first byte is discarded.
- R2: A strobed byte with bit 7 clear, received while no first byte is held, is appended to the narrow list. It is visible on the narrow read port and in `narrow_len` after that clock edge, and its code equals the byte.
- R3: A strobed byte with bit 7 set, received while no first byte is held, is held and changes neither list. The next strobed byte, whatever its bit 7, completes a wide character with code {held byte, new byte}, where the held byte occupies bits 15:8. That code is appended to the wide list.
- R4: A `del_narrow` pulse removes only the newest narrow entry and leaves the wide list untouched. For example, F,P,G,A becomes F,P,G and then F,P.
- R5: A `del_wide` pulse removes only the newest wide entry and leaves the narrow list and any held first byte untouched. The wide length never changes in a cycle that has neither a byte strobe nor a wide delete.
- R6: When an append and a delete to the same list fall in the same cycle, the append is applied first and the delete second, so the new character is removed. A length never grows by more than 1 per cycle.
- R7: Each list holds at most `DEPTH` entries (default 8). An append to a full list is dropped, and a length never exceeds `DEPTH`.
- R8: A delete pulse on an empty list has no effect.
- R9: A held first byte pairs with a strobed byte that arrives on any of the `TIMEOUT` clock edges after it (default 65536). If none arrives, the held byte is dropped and the next byte is classified afresh.
- R10: Each read port is combinational. For index i it returns valid=1 and the code of the (i+1)-th oldest entry when i is below the list length. Otherwise it returns valid=0 and code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_byte` |
| rx_byte | input | 8 | Received byte |
| del_narrow | input | 1 | One-cycle pulse: remove newest narrow character |
| del_wide | input | 1 | One-cycle pulse: remove newest wide character |
| narrow_rd_idx | input | $clog2(DEPTH) | Narrow list slot to read |
| narrow_rd_code | output | 8 | Code stored in that narrow slot |
| narrow_rd_valid | output | 1 | Narrow slot holds a character |
| narrow_len | output | $clog2(DEPTH+1) | Number of narrow characters |
| wide_rd_idx | input | $clog2(DEPTH) | Wide list slot to read |
| wide_rd_code | output | 16 | Code stored in that wide slot |
| wide_rd_valid | output | 1 | Wide slot holds a character |
| wide_len | output | $clog2(DEPTH+1) | Number of wide characters |

## Verification
Every stored result is due exactly one rising edge after the strobe or delete that causes it. The one exception is the first byte of a wide character, which changes no port until its partner arrives. The bench applies each stimulus at a falling edge and advances its queue model at the following rising edge. At the next falling edge it compares both lengths and sweeps every slot of both read ports, since those ports are combinational. The timeout is checked with a shortened `TIMEOUT`. The bench leaves a partner byte either `TIMEOUT` edges or `TIMEOUT+1` edges after the first byte, which exercises both sides of the window.

// File: rtl/dtb_pkg.sv
// Shared types for the dual-region character buffer.
package dtb_pkg;
    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;

    typedef logic [NARROW_W-1:0] byte_t;
    typedef logic [WIDE_W-1:0]   wide_t;

    // A byte opens a two-byte character when its top bit is set.
    function automatic logic opens_wide(input byte_t b);
        return b[NARROW_W-1];
    endfunction
endpackage

// File: rtl/dtb_byte_sorter.sv
// Classifies incoming bytes and pairs two-byte characters.
// Assumes rx_valid is a single-cycle strobe per byte. Push outputs are
// combinational from the strobe and the held-byte state, so the list
// registers capture them on the same edge. A held first byte is dropped
// after TIMEOUT edges without a byte.
module dtb_byte_sorter
    import dtb_pkg::*;
#(
    parameter int TIMEOUT = 65536
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_valid,
    input  byte_t rx_byte,
    output logic  push_narrow,
    output byte_t narrow_code,
    output logic  push_wide,
    output wide_t wide_code
);
    localparam int AW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [AW-1:0] AGE_LAST = AW'(TIMEOUT - 1);

    logic          held_q;
    byte_t         lead_q;
    logic [AW-1:0] age_q;

    // Route the current byte to one of the lists.
    always_comb begin
        push_wide   = rx_valid && held_q;
        push_narrow = rx_valid && !held_q && !opens_wide(rx_byte);
        wide_code   = {lead_q, rx_byte};
        narrow_code = rx_byte;
    end

    // Hold the first byte of a wide character and age it out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            lead_q <= '0;
            age_q  <= '0;
        end else if (rx_valid) begin
            if (held_q) begin
                held_q <= 1'b0;
            end else if (opens_wide(rx_byte)) begin
                held_q <= 1'b1;
                lead_q <= rx_byte;
                age_q  <= '0;
            end
        end else if (held_q) begin
            if (age_q == AGE_LAST) begin
                held_q <= 1'b0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtb_char_list.sv
// Append-only character list with backspace and a combinational read port.
// Within one cycle the append is applied before the delete. Appends beyond
// DEPTH are dropped, and deletes on an empty list do nothing. A slot at or
// above the length reads as code 0 with valid low.
module dtb_char_list #(
    parameter int CODE_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] push_code,
    input  logic              pop,
    input  logic [IW-1:0]     rd_idx,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_valid,
    output logic [LW-1:0]     len
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [CODE_W-1:0] slot_q [DEPTH];
    logic [LW-1:0]     len_q;
    logic [LW-1:0]     len_mid;
    logic [LW-1:0]     len_nxt;
    logic              accept;

    // Append first, then apply the delete to the result.
    always_comb begin
        accept  = push && (len_q != FULL);
        len_mid = len_q + LW'(accept);
        len_nxt = (pop && len_mid != '0) ? len_mid - 1'b1 : len_mid;
    end

    // Track the number of stored characters.
    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_nxt;
    end

    // Each slot captures the code when it is the next free position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             slot_q[g] <= '0;
            else if (accept && len_q == LW'(g))     slot_q[g] <= push_code;
        end
    end

    // Combinational read of one slot.
    always_comb begin
        rd_valid = (LW'(rd_idx) < len_q);
        rd_code  = rd_valid ? slot_q[rd_idx] : '0;
    end

    assign len = len_q;
endmodule

// File: rtl/dual_text_buffer.sv
// Top of the dual-region character buffer. It joins the byte sorter to a
// narrow list (single-byte codes) and a wide list (two-byte codes). All
// logic is on clk, with a synchronous active-low reset.
module dual_text_buffer
    import dtb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int TIMEOUT = 65536,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          del_narrow,
    input  logic          del_wide,
    input  logic [IW-1:0] narrow_rd_idx,
    output logic [7:0]    narrow_rd_code,
    output logic          narrow_rd_valid,
    output logic [LW-1:0] narrow_len,
    input  logic [IW-1:0] wide_rd_idx,
    output logic [15:0]   wide_rd_code,
    output logic          wide_rd_valid,
    output logic [LW-1:0] wide_len
);
    logic  push_narrow;
    logic  push_wide;
    byte_t narrow_code;
    wide_t wide_code;

    dtb_byte_sorter #(.TIMEOUT(TIMEOUT)) u_sorter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .push_narrow (push_narrow),
        .narrow_code (narrow_code),
        .push_wide   (push_wide),
        .wide_code   (wide_code)
    );

    dtb_char_list #(.CODE_W(NARROW_W), .DEPTH(DEPTH)) u_narrow (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_narrow),
        .push_code (narrow_code),
        .pop       (del_narrow),
        .rd_idx    (narrow_rd_idx),
        .rd_code   (narrow_rd_code),
        .rd_valid  (narrow_rd_valid),
        .len       (narrow_len)
    );

    dtb_char_list #(.CODE_W(WIDE_W), .DEPTH(DEPTH)) u_wide (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_wide),
        .push_code (wide_code),
        .pop       (del_wide),
        .rd_idx    (wide_rd_idx),
        .rd_code   (wide_rd_code),
        .rd_valid  (wide_rd_valid),
        .len       (wide_len)
    );
endmodule

// File: rtl/dtb_checker.sv
// Port-level temporal checks for dual_text_buffer, attached by bind.
module dtb_checker #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [7:0]    rx_byte,
    input logic          del_narrow,
    input logic          del_wide,
    input logic [LW-1:0] narrow_len,
    input logic [LW-1:0] wide_len
);
    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(narrow_len) <= DEPTH) && (int'(wide_len) <= DEPTH));

    assert_grow_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(narrow_len) <= int'($past(narrow_len)) + 1) &&
                 (int'(wide_len)   <= int'($past(wide_len)) + 1));

    assert_narrow_backspace_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (del_narrow && !rx_valid && narrow_len != '0)
        |=> int'(narrow_len) == int'($past(narrow_len)) - 1);

    assert_empty_delete_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (del_wide && !rx_valid && wide_len == '0) |=> wide_len == '0);

    assert_wide_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !del_wide) |=> $stable(wide_len));

    assert_lead_not_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte[7] && !del_narrow) |=> $stable(narrow_len));
endmodule

bind dual_text_buffer dtb_checker #(.DEPTH(DEPTH), .LW(LW)) u_dtb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .del_narrow (del_narrow),
    .del_wide   (del_wide),
    .narrow_len (narrow_len),
    .wide_len   (wide_len)
);

// File: tb/dual_text_buffer_bench.sv
`timescale 1ns/100ps
module dual_text_buffer_bench;
    localparam int D  = 8;
    localparam int TO = 16;
    localparam int IW = $clog2(D);
    localparam int LW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          del_narrow = 1'b0;
    logic          del_wide = 1'b0;
    logic [IW-1:0] narrow_rd_idx = '0;
    logic [7:0]    narrow_rd_code;
    logic          narrow_rd_valid;
    logic [LW-1:0] narrow_len;
    logic [IW-1:0] wide_rd_idx = '0;
    logic [15:0]   wide_rd_code;
    logic          wide_rd_valid;
    logic [LW-1:0] wide_len;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [7:0]  m_nar[$];
    logic [15:0] m_wid[$];
    bit          m_held = 0;
    logic [7:0]  m_lead = '0;
    int          m_age = 0;

    always #5 clk = ~clk;

    dual_text_buffer #(.DEPTH(D), .TIMEOUT(TO)) u_dual_text_buffer (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .del_narrow (del_narrow), .del_wide (del_wide),
        .narrow_rd_idx (narrow_rd_idx), .narrow_rd_code (narrow_rd_code),
        .narrow_rd_valid (narrow_rd_valid), .narrow_len (narrow_len),
        .wide_rd_idx (wide_rd_idx), .wide_rd_code (wide_rd_code),
        .wide_rd_valid (wide_rd_valid), .wide_len (wide_len)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare lengths and sweep every slot of both read ports (R10).
    task automatic compare_all(input string req);
        chk(req, "narrow_len", int'(narrow_len), m_nar.size());
        chk(req, "wide_len", int'(wide_len), m_wid.size());
        for (int i = 0; i < D; i++) begin
            narrow_rd_idx = IW'(i);
            wide_rd_idx   = IW'(i);
            #0.2;
            chk({req, "/R10"}, $sformatf("narrow valid[%0d]", i), int'(narrow_rd_valid), int'(i < m_nar.size()));
            chk({req, "/R10"}, $sformatf("narrow code[%0d]", i), int'(narrow_rd_code),
                (i < m_nar.size()) ? int'(m_nar[i]) : 0);
            chk({req, "/R10"}, $sformatf("wide valid[%0d]", i), int'(wide_rd_valid), int'(i < m_wid.size()));
            chk({req, "/R10"}, $sformatf("wide code[%0d]", i), int'(wide_rd_code),
                (i < m_wid.size()) ? int'(m_wid[i]) : 0);
        end
    endtask

    // One clock of stimulus, model update at the edge, comparison after it.
    task automatic step(input bit v, input logic [7:0] b, input bit dn, input bit dw, input string req);
        rx_valid = v; rx_byte = b; del_narrow = dn; del_wide = dw;
        @(posedge clk);
        if (v) begin
            if (m_held) begin
                if (m_wid.size() < D) m_wid.push_back({m_lead, b});
                m_held = 0;
            end else if (b[7]) begin
                m_held = 1; m_lead = b; m_age = 0;
            end else if (m_nar.size() < D) begin
                m_nar.push_back(b);
            end
        end else if (m_held) begin
            if (m_age == TO - 1) m_held = 0;
            else m_age++;
        end
        if (dn && m_nar.size() > 0) void'(m_nar.pop_back());
        if (dw && m_wid.size() > 0) void'(m_wid.pop_back());
        @(negedge clk);
        rx_valid = 0; del_narrow = 0; del_wide = 0;
        compare_all(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, req);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // R2: letters go to the narrow list
        step(1, 8'h46, 0, 0, "R2"); step(1, 8'h50, 0, 0, "R2");
        step(1, 8'h47, 0, 0, "R2"); step(1, 8'h41, 0, 0, "R2");
        // R3: two-byte characters, including a trail byte with bit 7 clear
        step(1, 8'hB9, 0, 0, "R3"); step(1, 8'hA2, 0, 0, "R3");
        step(1, 8'hD6, 0, 0, "R3"); step(1, 8'hDC, 0, 0, "R3");
        step(1, 8'hC1, 0, 0, "R3"); idle(2, "R3"); step(1, 8'h31, 0, 0, "R3");
        // R4: narrow backspace twice
        step(0, 8'h00, 1, 0, "R4"); step(0, 8'h00, 1, 0, "R4");
        // R5: wide backspace, also while a first byte is held
        step(0, 8'h00, 0, 1, "R5");
        step(1, 8'hE0, 0, 0, "R5"); step(0, 8'h00, 0, 1, "R5"); step(1, 8'h80, 0, 0, "R5");
        // R6: same-cycle append and delete
        step(1, 8'h5A, 1, 0, "R6");
        step(1, 8'hF1, 0, 0, "R6"); step(1, 8'hF2, 0, 1, "R6");
        // R7: overfill narrow, then push plus delete at full
        for (int i = 0; i < 10; i++) step(1, 8'h30 + 8'(i), 0, 0, "R7");
        step(1, 8'h7A, 1, 0, "R7");
        step(1, 8'h39, 0, 0, "R7");
        // R8: drain both lists and keep deleting
        for (int i = 0; i < 10; i++) step(0, 8'h00, 1, 1, "R8");
        step(0, 8'h00, 1, 1, "R8");
        // R9: partner on the last edge of the window pairs
        step(1, 8'hA5, 0, 0, "R9"); idle(TO - 1, "R9"); step(1, 8'h22, 0, 0, "R9");
        // R9: partner one edge late is classified afresh
        step(1, 8'hA6, 0, 0, "R9"); idle(TO, "R9"); step(1, 8'h23, 0, 0, "R9");
        // R1: reset in mid-stream clears lists and held byte
        step(1, 8'hB0, 0, 0, "R1");
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        m_nar.delete(); m_wid.delete(); m_held = 0;
        rst_n = 1'b1;
        compare_all("R1");
        step(1, 8'h44, 0, 0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule